// File: doc/BRIEF.md
# Counted-Character Transmit Front End

This block sits between a register write port and a serial line shifter. Software first writes a character count, then writes that many data words. The low byte of each accepted word goes into a small transmit FIFO. The FIFO feeds a byte/valid/ready handshake into the shifter, which is outside this block.

Data writes beyond the programmed count are discarded. When the last counted byte has been taken by the shifter, a sticky "transmit ready" flag is raised in an interrupt-status vector. That flag stays set until a command write clears it, so software must acknowledge each burst before it starts the next one. A mask register routes the flag to an interrupt pin.

A status vector reports whether the FIFO is empty. A reset-transmitter command flushes the FIFO and cancels any remaining count.

Top module: `txf_counted_front`

## Requirements
- R1: After reset, `ser_valid` is 0, `status[3]` is 1, `int_status[7]` is 0 and `irq` is 0.
- R2: A write to address 0 loads a count N from `wr_data[15:0]`. After it, exactly N data writes (address 1) are accepted. The accepted bytes reach `ser_data` in write order.
- R3: Only `wr_data[7:0]` of a data write is transmitted; the upper bits have no effect.
- R4: A data write is ignored, and does not use up any of the count, when the remaining count is zero or when the FIFO already holds DEPTH bytes.
- R5: `int_status[7]` goes to 1 in the cycle after the handshake (`ser_valid` and `ser_ready` both high) of the last counted byte. It then stays at 1.
- R6: A write to address 2 whose bits [11:8] equal 3 clears `int_status[7]`. If the last-byte handshake happens in the same cycle, the flag is set instead.
- R7: `irq` is 1 exactly when `int_status[7]` is 1 and bit 7 of the mask register (written at address 3) is 1.
- R8: A write to address 2 whose bits [7:4] equal 2 empties the FIFO and sets the remaining count to zero. In the next cycle `ser_valid` is 0 and `status[3]` is 1. Both command fields may be given in one write.
- R9: `status[3]` is 1 exactly when the FIFO holds no byte.
- R10: While `ser_valid` is 1 and `ser_ready` is 0, `ser_valid` and `ser_data` hold their values, unless a reset-transmitter command arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 count, 1 data, 2 command, 3 mask |
| wr_data | input | 32 | Write data |
| ser_data | output | 8 | Byte offered to the shifter |
| ser_valid | output | 1 | Byte offered |
| ser_ready | input | 1 | Shifter takes the byte this cycle |
| status | output | 8 | Status vector; bit 3 = FIFO empty |
| int_status | output | 8 | Interrupt status; bit 7 = burst done |
| irq | output | 1 | Masked interrupt |

## Verification
The bench sweeps the count from zero up to the FIFO depth. For each count it writes two extra words with non-zero upper bits and drains the FIFO. A design that missed the count gate would send the extra bytes. One that passed wide data would corrupt the bytes. One that raised the flag when the count was loaded, rather than at the last handshake, would flag zero-count or partial bursts.

A count larger than the depth, written while the shifter stalls, shows whether a dropped write wrongly uses up the count; if it did, the flag would appear early. A flush in the middle of a burst must leave later data writes without effect. The mask must gate the interrupt pin in both directions.

// File: rtl/txf_pkg.sv
package txf_pkg;
    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_DATA  = 2'd1,
        SEL_CMD   = 2'd2,
        SEL_MASK  = 2'd3
    } reg_sel_e;

    localparam int EMPTY_BIT     = 3;
    localparam int READY_BIT     = 7;
    localparam logic [3:0] OP_CLR_READY = 4'h3;
    localparam logic [3:0] OP_RST_TX    = 4'h2;

    typedef struct packed {
        logic load_count;
        logic data_wr;
        logic clr_ready;
        logic rst_tx;
        logic mask_wr;
    } wr_decode_t;
endpackage

// File: rtl/txf_decode.sv
module txf_decode
    import txf_pkg::*;
(
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    output wr_decode_t  dec
);
    reg_sel_e sel;

    always_comb begin
        sel            = reg_sel_e'(wr_addr);
        dec            = '0;
        dec.load_count = wr_en && (sel == SEL_COUNT);
        dec.data_wr    = wr_en && (sel == SEL_DATA);
        dec.mask_wr    = wr_en && (sel == SEL_MASK);
        dec.clr_ready  = wr_en && (sel == SEL_CMD) && (wr_data[11:8] == OP_CLR_READY);
        dec.rst_tx     = wr_en && (sel == SEL_CMD) && (wr_data[7:4]  == OP_RST_TX);
    end
endmodule

// File: rtl/txf_fifo.sv
module txf_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    input  logic          flush,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [LW-1:0]            level;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wp    = '0;
            st_d.rp    = '0;
            st_d.level = '0;
        end else begin
            if (push && !full) begin
                st_d.mem[st_q.wp] = din;
                st_d.wp           = bump(st_q.wp);
            end
            if (pop && !empty)
                st_d.rp = bump(st_q.rp);
            st_d.level = st_q.level + LW'(push && !full) - LW'(pop && !empty);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rp];
    assign empty = (st_q.level == '0);
    assign full  = (st_q.level == LW'(DEPTH));

    assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.level <= LW'(DEPTH));
    assert_full_push_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);
endmodule

// File: rtl/txf_counted_front.sv
module txf_counted_front
    import txf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    output logic [7:0]  ser_data,
    output logic        ser_valid,
    input  logic        ser_ready,
    output logic [7:0]  status,
    output logic [7:0]  int_status,
    output logic        irq
);
    typedef struct packed {
        logic [CNT_W-1:0] accept;
        logic [CNT_W-1:0] send;
        logic             ready;
        logic             mask;
    } front_st_t;

    front_st_t  st_d, st_q;
    wr_decode_t dec;
    logic       f_empty, f_full, f_push, f_pop;

    txf_decode i_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dec     (dec)
    );

    assign f_push = dec.data_wr && (st_q.accept != '0) && !f_full && !dec.rst_tx;
    assign f_pop  = ser_valid && ser_ready;

    txf_fifo #(.DEPTH(DEPTH), .DW(8)) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (f_push),
        .din   (wr_data[7:0]),
        .pop   (f_pop),
        .flush (dec.rst_tx),
        .dout  (ser_data),
        .empty (f_empty),
        .full  (f_full)
    );

    always_comb begin
        st_d = st_q;
        if (f_push)
            st_d.accept = st_q.accept - 1'b1;
        if (f_pop && st_q.send != '0)
            st_d.send = st_q.send - 1'b1;
        if (dec.load_count) begin
            st_d.accept = wr_data[CNT_W-1:0];
            st_d.send   = wr_data[CNT_W-1:0];
        end
        if (dec.rst_tx) begin
            st_d.accept = '0;
            st_d.send   = '0;
        end
        if (dec.mask_wr)
            st_d.mask = wr_data[READY_BIT];
        if (dec.clr_ready)
            st_d.ready = 1'b0;
        if (f_pop && st_q.send == CNT_W'(1))
            st_d.ready = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_valid = !f_empty;

    always_comb begin
        status                = '0;
        status[EMPTY_BIT]     = f_empty;
        int_status            = '0;
        int_status[READY_BIT] = st_q.ready;
    end

    assign irq = st_q.ready && st_q.mask;

    assert_ready_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_status[READY_BIT]) |-> $past(ser_valid && ser_ready));
    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (int_status[READY_BIT] && st_q.mask));
    assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec.rst_tx |=> (!ser_valid && status[EMPTY_BIT]));
    assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && !ser_ready && !dec.rst_tx) |=> (ser_valid && $stable(ser_data)));
    assert_ignore_no_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.data_wr && st_q.accept == '0 && !ser_valid) |=> !ser_valid);
endmodule

// File: tb/test_txf_counted_front.sv
module test_txf_counted_front;
    localparam int CLK_NS = 10;
    localparam int DEPTH  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  ser_data;
    logic        ser_valid;
    logic        ser_ready = 1'b0;
    logic [7:0]  status, int_status;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [7:0] got [0:15];
    int ngot;

    always #(CLK_NS/2) clk = ~clk;

    txf_counted_front #(.DEPTH(DEPTH), .CNT_W(16)) i_txf_counted_front (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ser_data(ser_data), .ser_valid(ser_valid), .ser_ready(ser_ready),
        .status(status), .int_status(int_status), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain(input int cycles);
        ngot = 0;
        @(negedge clk);
        ser_ready = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            if (ser_valid && ngot < 16) begin
                got[ngot] = ser_data;
                ngot++;
            end
            @(negedge clk);
        end
        ser_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", ser_valid, 0);
        check("R1 empty", status[3], 1);
        check("R1 ready", int_status[7], 0);
        check("R1 irq", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R9: sweep counts 0..DEPTH with two extra writes
        for (int n = 0; n <= DEPTH; n++) begin
            wr(2'd0, 32'(n));
            for (int i = 0; i < n + 2; i++)
                wr(2'd1, 32'hABCD_0000 | 32'((n * 16 + i) & 8'hFF) | 32'h0000_5500);
            check("R9 empty-after-load", status[3], (n == 0) ? 1 : 0);
            check("R4 ready-before-drain", int_status[7], 0);
            drain(3 * DEPTH + 4);
            check("R4 byte count", ngot, n);
            for (int i = 0; i < n; i++)
                check("R2 R3 byte", got[i], (n * 16 + i) & 8'hFF);
            check("R5 ready-after-burst", int_status[7], (n > 0) ? 1 : 0);
            check("R9 empty-after-drain", status[3], 1);
            wr(2'd2, 32'h0000_0300);
            check("R6 cleared", int_status[7], 0);
        end

        // R4: FIFO full must not use up the count
        ser_ready = 1'b0;
        wr(2'd0, 32'(DEPTH + 2));
        for (int i = 0; i < DEPTH + 2; i++)
            wr(2'd1, 32'(8'h40 + i));
        // R10: stalled output holds
        begin
            logic [7:0] held;
            held = ser_data;
            repeat (3) @(negedge clk);
            check("R10 valid held", ser_valid, 1);
            check("R10 data held", ser_data, held);
        end
        drain(3 * DEPTH + 4);
        check("R4 full drop count", ngot, DEPTH);
        check("R5 not yet", int_status[7], 0);
        wr(2'd1, 32'h0000_0077);
        wr(2'd1, 32'h0000_0078);
        drain(10);
        check("R4 late bytes", ngot, 2);
        check("R4 late byte0", got[0], 8'h77);
        check("R4 late byte1", got[1], 8'h78);
        check("R5 set after last", int_status[7], 1);

        // R7: mask gating
        check("R7 masked off", irq, 0);
        wr(2'd3, 32'h0000_0080);
        check("R7 unmasked", irq, 1);
        wr(2'd3, 32'h0000_0000);
        check("R7 remasked", irq, 0);
        wr(2'd3, 32'h0000_0080);
        wr(2'd2, 32'h0000_0300);
        check("R6 clear irq", irq, 0);
        check("R6 clear flag", int_status[7], 0);

        // R8: flush mid-burst, later data ignored
        wr(2'd0, 32'd3);
        wr(2'd1, 32'h11);
        wr(2'd1, 32'h22);
        check("R8 pre-flush valid", ser_valid, 1);
        wr(2'd2, 32'h0000_0020);
        check("R8 valid low", ser_valid, 0);
        check("R8 empty", status[3], 1);
        wr(2'd1, 32'h33);
        check("R8 count cancelled", status[3], 1);
        drain(6);
        check("R8 nothing sent", ngot, 0);
        check("R8 no ready", int_status[7], 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule